// File: doc/BRIEF.md
# Alternate Bus Master Takeover Controller

This block sits beside a local transfer engine that needs to become master of a shared asynchronous bus that a processor normally owns. When the engine raises its request, the block pulls the shared bus-request line low. It waits for the processor's grant, and then watches the bus until it is fully quiet. The bus is quiet when the processor's address strobe is idle, no slave is acknowledging a transfer, and no other alternate master still holds the grant-acknowledge line. Only then does the block pull grant-acknowledge low and tell the engine that it owns the bus.

All bus lines are active low and are shared by several devices. The block therefore never drives them high. Each of its two bus outputs is a pull-low enable for an open-drain driver, and an external pull-up returns the line to its idle level. The four bus inputs are asynchronous to the local clock and pass through a synchronizer chain before any decision uses them. Ownership lasts until the engine pulses done. The block then lets go of grant-acknowledge for one clock before it can accept a new request.

Top module: `bus_takeover`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_pull_o`, `gack_pull_o` and `bus_owned_o` are all 0.
- R2: One clock after `xfer_req_i` is seen high while the block is idle, `req_pull_o` becomes 1. It stays 1 for as long as the block waits for grant and quiet.
- R3: A grant (`bgrant_n_i` low) on its own does not cause ownership. While `strobe_n_i` is low, `gack_pull_o` stays 0.
- R4: While `dack_n_i` is low, `gack_pull_o` stays 0, even when grant is present and the strobe is idle.
- R5: While `gack_line_n_i` is low because another master holds it, `gack_pull_o` stays 0.
- R6: When grant is asserted and strobe, transfer acknowledge and the other grant-acknowledge are all idle, the block claims the bus. In the claim cycle `gack_pull_o` and `bus_owned_o` become 1 and `req_pull_o` becomes 0.
- R7: Ownership holds until `xfer_done_i` is seen high. On the next clock `gack_pull_o` and `bus_owned_o` fall to 0, and the block spends exactly one clock with both pulls at 0 before it returns to idle.
- R8: Each bus input passes through SYNC_STAGES flip-flops (default 2). When the last blocking input goes idle, the claim shows on the outputs SYNC_STAGES+1 clock edges later.
- R9: If grant goes away while the block waits for quiet, the block keeps requesting and does not claim. If `xfer_req_i` drops before grant arrives, `req_pull_o` returns to 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_req_i | input | 1 | Local engine wants the bus (level) |
| xfer_done_i | input | 1 | Local engine has finished (pulse while owning) |
| bgrant_n_i | input | 1 | Processor bus grant, active low, asynchronous |
| strobe_n_i | input | 1 | Bus address strobe, active low, asynchronous |
| dack_n_i | input | 1 | Bus transfer acknowledge, active low, asynchronous |
| gack_line_n_i | input | 1 | Shared grant-acknowledge line, active low, asynchronous |
| req_pull_o | output | 1 | Pull the shared bus-request line low |
| gack_pull_o | output | 1 | Pull the shared grant-acknowledge line low |
| bus_owned_o | output | 1 | The local engine may use the bus |

## Verification
The main function is exercised with several different stimulus patterns. In one, grant arrives while the processor's strobe is still active and goes idle some clocks later. In another, a slave holds transfer acknowledge after the strobe has gone idle. In a third, a competing master keeps the grant-acknowledge line asserted. Each pattern blocks the claim for a different reason, so a design that ignores any one of the four conditions claims too early in exactly one of them. A further pattern withdraws the grant during the wait, and another drops the local request before any grant arrives; these separate retreating to the request state from retreating to idle. Counting the edges from the last blocking input going idle to the claim shows the synchronizer depth, and each claim is also checked against the raw inputs from two edges earlier.

// File: rtl/tko_pkg.sv
package tko_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_WAIT_QUIET,
        ST_OWN,
        ST_RELEASE
    } tko_state_e;

    // registered controller state: phase plus the two bus pulls
    typedef struct packed {
        tko_state_e state;
        logic       req_pull;
        logic       gack_pull;
    } tko_regs_t;

    localparam tko_regs_t TKO_RESET = '{state: ST_IDLE, req_pull: 1'b0, gack_pull: 1'b0};

endpackage

// File: rtl/tko_sync.sv
module tko_sync #(
    parameter int                 WIDTH   = 4,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= chain_d[i];
        end
    end

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/tko_gate.sv
module tko_gate (
    input  logic grant_seen,
    input  logic strobe_busy,
    input  logic dack_busy,
    input  logic other_own,
    output logic claim_ok,
    output logic grant_lost
);

    logic bus_active;

    always_comb begin
        bus_active = strobe_busy | dack_busy | other_own;
        claim_ok   = grant_seen & ~bus_active;
        grant_lost = ~grant_seen;
    end

endmodule

// File: rtl/tko_fsm.sv
module tko_fsm
    import tko_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_req_i,
    input  logic xfer_done_i,
    input  logic grant_seen,
    input  logic grant_lost,
    input  logic claim_ok,
    output logic req_pull_o,
    output logic gack_pull_o,
    output logic bus_owned_o
);

    tko_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (xfer_req_i) r_d.state = ST_REQUEST;
            end
            ST_REQUEST: begin
                if (!xfer_req_i)     r_d.state = ST_IDLE;
                else if (grant_seen) r_d.state = ST_WAIT_QUIET;
            end
            ST_WAIT_QUIET: begin
                if (grant_lost)    r_d.state = ST_REQUEST;
                else if (claim_ok) r_d.state = ST_OWN;
            end
            ST_OWN: begin
                if (xfer_done_i) r_d.state = ST_RELEASE;
            end
            ST_RELEASE: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
        r_d.req_pull  = (r_d.state == ST_REQUEST) || (r_d.state == ST_WAIT_QUIET);
        r_d.gack_pull = (r_d.state == ST_OWN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= TKO_RESET;
        else        r_q <= r_d;
    end

    assign req_pull_o  = r_q.req_pull;
    assign gack_pull_o = r_q.gack_pull;
    assign bus_owned_o = r_q.gack_pull;

endmodule

// File: rtl/bus_takeover.sv
module bus_takeover #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_req_i,
    input  logic xfer_done_i,
    input  logic bgrant_n_i,
    input  logic strobe_n_i,
    input  logic dack_n_i,
    input  logic gack_line_n_i,
    output logic req_pull_o,
    output logic gack_pull_o,
    output logic bus_owned_o
);

    localparam int NUM_ASYNC = 4;

    logic [NUM_ASYNC-1:0] raw_n;
    logic [NUM_ASYNC-1:0] synced_n;
    logic grant_seen, strobe_busy, dack_busy, other_own;
    logic claim_ok, grant_lost;

    assign raw_n = {gack_line_n_i, dack_n_i, strobe_n_i, bgrant_n_i};

    tko_sync #(
        .WIDTH   (NUM_ASYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({NUM_ASYNC{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_n),
        .sync_o  (synced_n)
    );

    assign grant_seen  = ~synced_n[0];
    assign strobe_busy = ~synced_n[1];
    assign dack_busy   = ~synced_n[2];
    assign other_own   = ~synced_n[3];

    tko_gate u_gate (
        .grant_seen  (grant_seen),
        .strobe_busy (strobe_busy),
        .dack_busy   (dack_busy),
        .other_own   (other_own),
        .claim_ok    (claim_ok),
        .grant_lost  (grant_lost)
    );

    tko_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_req_i  (xfer_req_i),
        .xfer_done_i (xfer_done_i),
        .grant_seen  (grant_seen),
        .grant_lost  (grant_lost),
        .claim_ok    (claim_ok),
        .req_pull_o  (req_pull_o),
        .gack_pull_o (gack_pull_o),
        .bus_owned_o (bus_owned_o)
    );

endmodule

// File: rtl/tko_checker.sv
module tko_checker (
    input logic clk,
    input logic rst_n,
    input logic xfer_req_i,
    input logic req_pull_o,
    input logic gack_pull_o,
    input logic grant_seen,
    input logic strobe_busy,
    input logic dack_busy,
    input logic other_own
);

    // R3 R4 R5 R6: a claim only follows a cycle in which all four conditions held
    a_r6_claim_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gack_pull_o) |-> $past(grant_seen && !strobe_busy && !dack_busy && !other_own));

    // R6: the request line is released whenever ownership is held
    a_r6_request_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        gack_pull_o |-> !req_pull_o);

    // R7: one clock with both pulls released after ownership ends
    a_r7_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gack_pull_o) |-> (!gack_pull_o && !req_pull_o) ##1 !gack_pull_o);

    // R2: a request is raised only because the engine asked
    a_r2_request_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_pull_o) |-> $past(xfer_req_i));

    // R9: no claim while the grant is absent
    a_r9_no_claim_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pull_o && !grant_seen) |=> !gack_pull_o);

endmodule

bind bus_takeover tko_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_req_i  (xfer_req_i),
    .req_pull_o  (req_pull_o),
    .gack_pull_o (gack_pull_o),
    .grant_seen  (grant_seen),
    .strobe_busy (strobe_busy),
    .dack_busy   (dack_busy),
    .other_own   (other_own)
);

// File: tb/bus_takeover_test.sv
module bus_takeover_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_req_i = 1'b0, xfer_done_i = 1'b0;
    logic bgrant_n_i = 1'b1, strobe_n_i = 1'b1, dack_n_i = 1'b1, gack_line_n_i = 1'b1;
    logic req_pull_o, gack_pull_o, bus_owned_o;

    int total = 0;
    int bad   = 0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_takeover uut (
        .clk(clk), .rst_n(rst_n), .xfer_req_i(xfer_req_i), .xfer_done_i(xfer_done_i),
        .bgrant_n_i(bgrant_n_i), .strobe_n_i(strobe_n_i), .dack_n_i(dack_n_i),
        .gack_line_n_i(gack_line_n_i), .req_pull_o(req_pull_o),
        .gack_pull_o(gack_pull_o), .bus_owned_o(bus_owned_o)
    );

    // reference model: phase 0 idle, 1 asking, 2 waiting for quiet, 3 owner, 4 letting go
    int  m_phase;
    bit  s1 [4];
    bit  s2 [4];
    bit  blk_hist [3];

    always @(posedge clk or negedge rst_n) begin
        bit raw [4];
        raw[0] = !bgrant_n_i; raw[1] = !strobe_n_i; raw[2] = !dack_n_i; raw[3] = !gack_line_n_i;
        if (!rst_n) begin
            m_phase = 0;
            for (int i = 0; i < 4; i++) begin s1[i] = 0; s2[i] = 0; end
            for (int i = 0; i < 3; i++) blk_hist[i] = 1;
        end else begin
            case (m_phase)
                0: if (xfer_req_i) m_phase = 1;
                1: if (!xfer_req_i) m_phase = 0; else if (s2[0]) m_phase = 2;
                2: if (!s2[0]) m_phase = 1;
                   else if (!s2[1] && !s2[2] && !s2[3]) m_phase = 3;
                3: if (xfer_done_i) m_phase = 4;
                default: m_phase = 0;
            endcase
            for (int i = 0; i < 4; i++) begin s2[i] = s1[i]; s1[i] = raw[i]; end
            blk_hist[2] = blk_hist[1];
            blk_hist[1] = blk_hist[0];
            blk_hist[0] = !raw[0] || raw[1] || raw[2] || raw[3];
        end
    end

    task automatic check(input logic act, input logic exp, input string rq, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", rq, what, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison and claim safety, sampled on the falling edge
    logic prev_own = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            check(req_pull_o,  (m_phase == 1 || m_phase == 2), tag, "req_pull vs model");
            check(gack_pull_o, (m_phase == 3), tag, "gack_pull vs model");
            check(bus_owned_o, (m_phase == 3), tag, "owned vs model");
            if (gack_pull_o && !prev_own)
                check(blk_hist[2], 1'b0, "R6", "claim with blocking input two edges back (R3 R4 R5)");
            prev_own = gack_pull_o;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic finish_own();
        tag = "R7";
        step(4);
        check(bus_owned_o, 1'b1, "R7", "ownership held before done");
        xfer_done_i = 1'b1; xfer_req_i = 1'b0;
        step(1);
        xfer_done_i = 1'b0;
        check(gack_pull_o, 1'b0, "R7", "gack released after done");
        check(req_pull_o,  1'b0, "R7", "no request in release clock");
        step(1);
        check(gack_pull_o, 1'b0, "R7", "idle after release");
        bgrant_n_i = 1'b1; strobe_n_i = 1'b1; dack_n_i = 1'b1; gack_line_n_i = 1'b1;
        step(4);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        report();
    end

    initial begin
        step(2);
        check(req_pull_o, 1'b0, "R1", "req in reset");
        check(gack_pull_o, 1'b0, "R1", "gack in reset");
        rst_n = 1'b1;
        step(1);
        check(bus_owned_o, 1'b0, "R1", "owned after reset");

        // grant arrives while the processor strobe is still busy (R3, R8)
        tag = "R3";
        strobe_n_i = 1'b0;
        xfer_req_i = 1'b1;
        step(1);
        check(req_pull_o, 1'b1, "R2", "request raised");
        step(2);
        bgrant_n_i = 1'b0;
        step(6);
        check(gack_pull_o, 1'b0, "R3", "no claim with grant while strobe busy");
        check(req_pull_o, 1'b1, "R2", "request held while waiting");
        strobe_n_i = 1'b1;
        tag = "R8";
        step(2);
        check(gack_pull_o, 1'b0, "R8", "claim not yet visible through synchronizer");
        step(1);
        check(gack_pull_o, 1'b1, "R8", "claim after sync delay");
        check(req_pull_o, 1'b0, "R6", "request dropped on claim");
        finish_own();

        // slave still acknowledging (R4)
        tag = "R4";
        dack_n_i = 1'b0; bgrant_n_i = 1'b0; xfer_req_i = 1'b1;
        step(8);
        check(gack_pull_o, 1'b0, "R4", "no claim while dack busy");
        dack_n_i = 1'b1;
        step(4);
        check(bus_owned_o, 1'b1, "R6", "claim after dack idle");
        finish_own();

        // competing master still holds grant acknowledge (R5)
        tag = "R5";
        gack_line_n_i = 1'b0; bgrant_n_i = 1'b0; xfer_req_i = 1'b1;
        step(9);
        check(gack_pull_o, 1'b0, "R5", "no claim while other master owns");
        gack_line_n_i = 1'b1;
        step(4);
        check(gack_pull_o, 1'b1, "R6", "claim after other master leaves");
        finish_own();

        // grant withdrawn during the wait (R9)
        tag = "R9";
        strobe_n_i = 1'b0; bgrant_n_i = 1'b0; xfer_req_i = 1'b1;
        step(6);
        bgrant_n_i = 1'b1;
        step(2);
        strobe_n_i = 1'b1;
        step(5);
        check(gack_pull_o, 1'b0, "R9", "no claim after grant withdrawn");
        check(req_pull_o, 1'b1, "R9", "still requesting after grant withdrawn");
        bgrant_n_i = 1'b0;
        step(6);
        check(gack_pull_o, 1'b1, "R9", "claim once grant returns");
        finish_own();

        // engine gives up before any grant (R9)
        tag = "R9";
        xfer_req_i = 1'b1;
        step(3);
        check(req_pull_o, 1'b1, "R2", "request before withdrawal");
        xfer_req_i = 1'b0;
        step(1);
        check(req_pull_o, 1'b0, "R9", "request dropped when engine withdraws");
        step(3);
        report();
    end

endmodule